// File: doc/BRIEF.md
# Inactivity Halt and Wake Controller

This block decides when a keypad companion chip may stop its clock. It watches key events, host bus traffic and the level of any unresolved interrupt. From these it counts a quiet period in millisecond ticks. When the host-programmed number of ticks passes with no activity and no pending interrupt, it raises a halt request. The clock-gating cell, which sits outside this block, acts on that request.

While halted, the block watches for wake sources: a bus start condition, other bus activity, an edge on one of the interrupt-capable general-purpose pins, or a key held down on the active-low sense inputs. Any one of them ends the halt. A wake also sets a flag that tells the bus slave to refuse, with a negative acknowledge, the next address phase it sees, so that the host sends it again. The flag clears once one refused address phase has been reported.

The block carries no data, so it has no valid/ready stream. Every pin is a plain control or status level, or a single-cycle strobe.

Top module: `hw_halt_ctrl`

## Requirements
- R1: After reset, `halt_req` and `nack_first` are both 0, and the quiet counter holds the default period of 500 ticks.
- R2: In the active state, `halt_req` rises in the cycle after the N-th `ms_tick` that follows the last activity, where N is `tmo_ms`. No activity and no pending interrupt may occur in between.
- R3: A `tmo_ms` value of 0 selects the default period of 500 ticks.
- R4: A `key_evt`, `bus_act` or `bus_start` strobe in the active state reloads the counter to the full period.
- R5: While `irq_pending` is 1, halt is never entered, and the counter is held at the full period.
- R6: While halted, `bus_start` or `bus_act` clears `halt_req` in the next cycle.
- R7: While halted, a change of level on any bit of `pin_wake`, measured against the previous cycle, clears `halt_req` in the next cycle.
- R8: While halted, any bit of `key_sense` at 0 (active low) clears `halt_req` in the next cycle.
- R9: Every wake sets `nack_first` to 1. In the active state, one `addr_done` strobe clears it.
- R10: When a wake and `addr_done` fall in the same cycle, the wake wins and `nack_first` is 1 afterwards.
- R11: While halted, `ms_tick` and `irq_pending` have no effect, and `halt_req` stays 1.
- R12: An activity strobe in the same cycle as the final tick of the period reloads the counter, and halt is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| key_evt | input | 1 | Strobe for a key press or key release event |
| bus_act | input | 1 | Strobe for host bus activity |
| bus_start | input | 1 | Strobe for a detected bus start condition |
| irq_pending | input | 1 | Level: an interrupt is still unresolved |
| pin_wake | input | N_PIN | Levels of the interrupt-capable general-purpose pins |
| key_sense | input | N_KEY | Keypad sense inputs, active low |
| tmo_ms | input | TMO_W | Quiet period in ticks; 0 selects 500 |
| addr_done | input | 1 | Strobe from the bus slave: one address phase refused |
| halt_req | output | 1 | Request to stop the clock |
| nack_first | output | 1 | Tells the slave to refuse the next address phase |

## Verification
Two pairs of events can fall in the same cycle. The first is a wake together with the slave reporting a refused address phase. The second is an activity strobe together with the tick that would end the quiet period. The bench provokes both pairs directly: a bus strobe arrives with `addr_done` while halted, and a key event lands on the final tick. It then expects `nack_first` at 1 and `halt_req` at 0. Random stimulus adds many more such overlaps, and a cycle model in the bench, built from the requirements, judges each of them.

// File: rtl/hw_pkg.sv
package hw_pkg;
  typedef enum logic {ST_ACTIVE = 1'b0, ST_HALT = 1'b1} hw_state_t;
  localparam int HW_DEFAULT_MS = 500;
endpackage

// File: rtl/hw_idle_timer.sv
module hw_idle_timer #(
  parameter int TMO_W = 16,
  parameter int DEF_MS = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic             tick,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  localparam logic [TMO_W-1:0] DEF_CNT = TMO_W'(DEF_MS);
  logic [TMO_W-1:0] cnt_q;

  assign expire = run && !reload && tick && (cnt_q <= TMO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= DEF_CNT;
    else if (reload)
      cnt_q <= limit;
    else if (expire)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= cnt_q - TMO_W'(1);
  end
endmodule

// File: rtl/hw_wake_detect.sv
module hw_wake_detect #(
  parameter int N_PIN = 2,
  parameter int N_KEY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halted,
  input  logic             bus_start,
  input  logic             bus_act,
  input  logic [N_PIN-1:0] pin_wake,
  input  logic [N_KEY-1:0] key_sense,
  output logic             wake
);
  logic [N_PIN-1:0] pin_q;
  logic [N_PIN-1:0] pin_edge;

  for (genvar g = 0; g < N_PIN; g++) begin : g_edge
    assign pin_edge[g] = pin_wake[g] ^ pin_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_wake;
  end

  assign wake = halted && (bus_start || bus_act || (|pin_edge) || !(&key_sense));
endmodule

// File: rtl/hw_nack_guard.sv
module hw_nack_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wake,
  input  logic addr_done,
  output logic nack_first
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         nack_first <= 1'b0;
    else if (wake)      nack_first <= 1'b1;
    else if (addr_done) nack_first <= 1'b0;
  end
endmodule

// File: rtl/hw_halt_ctrl.sv
module hw_halt_ctrl
  import hw_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int N_PIN = 2,
  parameter int N_KEY = 8,
  parameter int DEF_MS = HW_DEFAULT_MS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             key_evt,
  input  logic             bus_act,
  input  logic             bus_start,
  input  logic             irq_pending,
  input  logic [N_PIN-1:0] pin_wake,
  input  logic [N_KEY-1:0] key_sense,
  input  logic [TMO_W-1:0] tmo_ms,
  input  logic             addr_done,
  output logic             halt_req,
  output logic             nack_first
);
  localparam logic [TMO_W-1:0] DEF_LIM = TMO_W'(DEF_MS);

  hw_state_t  state_q;
  logic       halted;
  logic       wake;
  logic       expire;
  logic       hold;
  logic [TMO_W-1:0] limit;

  assign halted = (state_q == ST_HALT);
  assign limit  = (tmo_ms == '0) ? DEF_LIM : tmo_ms;
  assign hold   = (!halted && (key_evt || bus_act || bus_start || irq_pending)) || wake;

  hw_idle_timer #(.TMO_W(TMO_W), .DEF_MS(DEF_MS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(!halted), .reload(hold),
    .tick(ms_tick), .limit(limit), .expire(expire)
  );

  hw_wake_detect #(.N_PIN(N_PIN), .N_KEY(N_KEY)) u_wake (
    .clk(clk), .rst_n(rst_n), .halted(halted), .bus_start(bus_start),
    .bus_act(bus_act), .pin_wake(pin_wake), .key_sense(key_sense), .wake(wake)
  );

  hw_nack_guard u_nack (
    .clk(clk), .rst_n(rst_n), .wake(wake), .addr_done(addr_done),
    .nack_first(nack_first)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= ST_ACTIVE;
    else if (wake)   state_q <= ST_ACTIVE;
    else if (expire) state_q <= ST_HALT;
  end

  assign halt_req = halted;
endmodule

// File: rtl/hw_halt_ctrl_chk.sv
module hw_halt_ctrl_chk #(
  parameter int N_KEY = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             bus_act,
  input logic             bus_start,
  input logic             irq_pending,
  input logic [N_KEY-1:0] key_sense,
  input logic             addr_done,
  input logic             halt_req,
  input logic             nack_first
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!halt_req && !nack_first));
  a_r2_entry_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(ms_tick));
  a_r5_irq_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !halt_req) |=> !halt_req);
  a_r6_bus_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && (bus_start || bus_act)) |=> !halt_req);
  a_r8_key_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !(&key_sense)) |=> !halt_req);
  a_r9_nack_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_req) |-> nack_first);
  a_r9_nack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_first && addr_done && !halt_req) |=> !nack_first);
endmodule

bind hw_halt_ctrl hw_halt_ctrl_chk #(.N_KEY(N_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bus_act(bus_act),
  .bus_start(bus_start), .irq_pending(irq_pending), .key_sense(key_sense),
  .addr_done(addr_done), .halt_req(halt_req), .nack_first(nack_first)
);

// File: tb/test_hw_halt_ctrl.sv
module test_hw_halt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEF = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ms_tick = 0, key_evt = 0, bus_act = 0, bus_start = 0, irq_pending = 0, addr_done = 0;
  logic [1:0] pin_wake = '0;
  logic [7:0] key_sense = 8'hFF;
  logic [15:0] tmo_ms = '0;
  logic halt_req, nack_first;

  int n_chk = 0, n_fail = 0;
  bit m_halt = 0, m_nack = 0;
  int m_cnt = DEF;
  logic [1:0] m_pin = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_halt_ctrl i_hw_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .key_evt(key_evt), .bus_act(bus_act),
    .bus_start(bus_start), .irq_pending(irq_pending), .pin_wake(pin_wake),
    .key_sense(key_sense), .tmo_ms(tmo_ms), .addr_done(addr_done),
    .halt_req(halt_req), .nack_first(nack_first)
  );

  function automatic int lim_of(input logic [15:0] t);
    return (t == 0) ? DEF : int'(t);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit wk;
    if (!m_halt) begin
      if (key_evt || bus_act || bus_start || irq_pending) m_cnt = lim_of(tmo_ms);
      else if (ms_tick) begin
        if (m_cnt <= 1) begin m_halt = 1; m_cnt = 0; end
        else m_cnt--;
      end
      if (addr_done) m_nack = 0;
    end else begin
      wk = bus_start || bus_act || (pin_wake != m_pin) || !(&key_sense);
      if (wk) begin m_halt = 0; m_cnt = lim_of(tmo_ms); m_nack = 1; end
      else if (addr_done) m_nack = 0;
    end
    m_pin = pin_wake;
  endtask

  task automatic drive(input bit k, b, s, i, t, a, input logic [7:0] ks);
    key_evt = k; bus_act = b; bus_start = s; irq_pending = i; ms_tick = t;
    addr_done = a; key_sense = ks;
    model_step();
    @(negedge clk);
    chk("R2 model halt_req", halt_req, m_halt);
    chk("R9 model nack_first", nack_first, m_nack);
  endtask

  task automatic ticks(input int n);
    for (int j = 0; j < n; j++) drive(0, 0, 0, 0, 1, 0, 8'hFF);
  endtask

  task automatic go_halt();
    ticks(tmo_ms == 0 ? DEF : int'(tmo_ms));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 halt_req reset", halt_req, 0);
    chk("R1 nack_first reset", nack_first, 0);
    rst_n = 1;
    tmo_ms = 16'd4;
    drive(1, 0, 0, 0, 0, 0, 8'hFF);
    ticks(3);
    chk("R2 not yet", halt_req, 0);
    ticks(1);
    chk("R2 halted after 4 ticks", halt_req, 1);
    drive(0, 0, 0, 1, 1, 0, 8'hFF); ticks(5);
    chk("R11 tick/irq ignored in halt", halt_req, 1);
    drive(0, 0, 1, 0, 0, 0, 8'hFF);
    chk("R6 bus start wakes", halt_req, 0);
    chk("R9 nack set on wake", nack_first, 1);
    drive(0, 0, 0, 0, 0, 1, 8'hFF);
    chk("R9 nack cleared", nack_first, 0);
    go_halt();
    drive(0, 0, 0, 0, 0, 0, 8'hFB);
    chk("R8 key sense wakes", halt_req, 0);
    go_halt();
    pin_wake = 2'b10;
    drive(0, 0, 0, 0, 0, 0, 8'hFF);
    chk("R7 pin edge wakes", halt_req, 0);
    for (int j = 0; j < 10; j++) drive(0, 0, 0, 1, 1, 0, 8'hFF);
    chk("R5 irq blocks halt", halt_req, 0);
    ticks(3);
    chk("R5 full period after release", halt_req, 0);
    ticks(1);
    chk("R5 halt after release", halt_req, 1);
    drive(0, 1, 0, 0, 0, 1, 8'hFF);
    chk("R10 wake beats addr_done", nack_first, 1);
    chk("R6 bus act wakes", halt_req, 0);
    ticks(3); drive(1, 0, 0, 0, 0, 0, 8'hFF); ticks(3);
    chk("R4 reload on key event", halt_req, 0);
    ticks(1);
    chk("R4 halt after reload", halt_req, 1);
    drive(0, 1, 0, 0, 0, 0, 8'hFF);
    ticks(3); drive(1, 0, 0, 0, 1, 0, 8'hFF);
    chk("R12 activity on final tick", halt_req, 0);
    ticks(3);
    chk("R12 reloaded", halt_req, 0);
    tmo_ms = 16'd0;
    drive(0, 1, 0, 0, 0, 0, 8'hFF);
    ticks(DEF - 1);
    chk("R3 default not yet", halt_req, 0);
    ticks(1);
    chk("R3 default period", halt_req, 1);
    drive(0, 0, 1, 0, 0, 0, 8'hFF);
    for (int n = 0; n < 4000; n++) begin
      if ((n % 500) == 0) tmo_ms = 16'($urandom_range(0, 6));
      if ($urandom_range(0, 15) == 0) pin_wake = 2'($urandom);
      drive($urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0, $urandom_range(0, 29) == 0,
            $urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
            ($urandom_range(0, 24) == 0) ? 8'($urandom) : 8'hFF);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule